// File: doc/BRIEF.md
# CAN Receive Buffer Assembler

This block takes received CAN frames for one message object and writes them, one byte per cycle, into a circular byte buffer in on-chip memory. The buffer starts at a programmed base address and holds a programmed number of bytes. Write addresses are generated inside the block.

The block has two modes. In transport mode, each frame carries a fragmentation byte that the block decodes but never stores. The data of consecutive fragments is packed back to back, and when the final fragment ends the block writes the message byte count into the first slot of the buffer. In raw buffering mode, every frame is stored as a packed header byte followed by its data bytes. A full flag reports when the space left could not hold another maximum-size frame. In both modes, a one-cycle warning interrupt fires before the write pointer wraps, so software can drain the buffer.

Frame input is a simple stream. A start strobe carries the header fields, one data byte is offered per cycle with a valid strobe, and a done strobe follows the last byte. None of these strobes coincide. Every memory write appears on the port in the cycle after the input that causes it.

Top module: `can_rx_assembler`

## Requirements
- R1: After reset, `mem_we`, `irq_wrap_warn` and `buf_full` are low, and the write offset is 0.
- R2: In raw mode (`cfg_frag_en`=1, `cfg_mode`=00), a frame start writes a header byte at the current offset: bit 7 IDE, bit 6 RTR, bit 5 SEM1, bit 4 SEM0, bits 3:0 DLC. Data bytes 1..DLC follow at consecutive offsets.
- R3: Only the first min(DLC,8) data bytes of a frame are considered. Any further bytes offered in that frame cause no write.
- R4: On each frame done in raw mode, `buf_full` becomes 1 exactly when `cfg_size` minus the current offset is below 9. `buf_full` is 0 whenever the block is not in raw mode.
- R5: The address written is `cfg_base` plus the offset. After a write at offset `cfg_size`-1, the next offset is 1, not 0. Every write stays inside the buffer.
- R6: `irq_wrap_warn` is a one-cycle pulse in the same cycle as the write that leaves fewer than `cfg_warn_thr` bytes before the top. It fires at most once until the pointer wraps or a new message restarts it.
- R7: In transport mode (`cfg_frag_en`=1, `cfg_mode`≠00), data byte 1 of each frame is never written. Bytes 2..DLC are written.
- R8: The fragmentation byte holds a kind in bits 7:6 and a counter in bits 5:0. The kinds are 00 single, 01 first, 10 middle and 11 last. A single or first fragment restarts the message at offset 1. Middle and last fragments append directly after the stored data when their counter equals the previous counter plus 1.
- R9: On done of an accepted last or single fragment, the count of stored data bytes (modulo 256, fragmentation bytes excluded) is written at offset 0. This write comes one cycle after the done strobe and after all of the message's data.
- R10: A middle or last fragment with a wrong counter, or one that arrives with no message open, aborts the message. Its frame data and any byte count are discarded, and the next message starts at offset 1.
- R11: While `cfg_frag_en` is 0, no frame input causes a memory write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mode | input | 2 | Protocol mode, 00 = raw CAN buffering, other codes = transport |
| cfg_frag_en | input | 1 | Enables buffering for this object |
| cfg_base | input | AW | Buffer base address |
| cfg_size | input | AW | Buffer size in bytes |
| cfg_warn_thr | input | AW | Remaining-space level that triggers the wrap warning |
| frm_start | input | 1 | Frame start strobe, header fields valid |
| frm_ide | input | 1 | Extended identifier flag of the frame |
| frm_rtr | input | 1 | Remote request flag of the frame |
| frm_sem1 | input | 1 | Semaphore bit 1 |
| frm_sem0 | input | 1 | Semaphore bit 0 |
| frm_dlc | input | 4 | Data length code |
| dat_valid | input | 1 | Data byte strobe |
| dat_byte | input | 8 | Data byte, in frame order |
| frm_done | input | 1 | End of frame strobe |
| mem_we | output | 1 | Memory byte write enable |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| irq_wrap_warn | output | 1 | Wrap warning pulse |
| buf_full | output | 1 | Raw mode buffer full flag |

## Verification
The byte that lands in the top slot of the buffer does two things in the same cycle: it completes a data write and it moves the pointer back to offset 1, which also re-arms the warning. To provoke this, the raw frame sequence is sized so that the last frame's data runs past the top. Its seventh and eighth bytes must appear at offsets 1 and 2, and the warning must have pulsed exactly once, at the write that crossed the threshold. The full evaluation at that frame's done strobe must then see the wrapped offset and drop the flag it raised one frame earlier.

// File: rtl/canrx_pkg.sv
package canrx_pkg;

    localparam logic [1:0] MODE_RAW   = 2'b00;
    localparam int         MAX_DATA   = 8;
    localparam int         FULL_ROOM  = 9;

    typedef enum logic [1:0] {
        FK_SINGLE = 2'b00,
        FK_FIRST  = 2'b01,
        FK_MIDDLE = 2'b10,
        FK_LAST   = 2'b11
    } frag_kind_e;

endpackage

// File: rtl/canrx_info_pack.sv
module canrx_info_pack (
    input  logic       ide,
    input  logic       rtr,
    input  logic       sem1,
    input  logic       sem0,
    input  logic [3:0] dlc,
    output logic [7:0] info
);
    // header byte layout: flags high, length low
    assign info = {ide, rtr, sem1, sem0, dlc};
endmodule

// File: rtl/canrx_frag_check.sv
module canrx_frag_check #(
    parameter int CW = 6
) (
    input  logic [7:0]    fbyte,
    input  logic          in_msg,
    input  logic [CW-1:0] exp_cnt,
    output logic          ok,
    output logic          opens,
    output logic          closes,
    output logic [CW-1:0] nxt_cnt
);
    import canrx_pkg::*;

    frag_kind_e    kind;
    logic [CW-1:0] cnt;

    assign kind    = frag_kind_e'(fbyte[7:6]);
    assign cnt     = fbyte[CW-1:0];
    assign nxt_cnt = cnt + CW'(1);

    always_comb begin
        opens  = (kind == FK_SINGLE) || (kind == FK_FIRST);
        closes = (kind == FK_SINGLE) || (kind == FK_LAST);
        ok     = opens || (in_msg && (cnt == exp_cnt));
    end
endmodule

// File: rtl/canrx_ring.sv
module canrx_ring #(
    parameter int AW = 10
) (
    input  logic [AW-1:0] ptr,
    input  logic [AW-1:0] size,
    input  logic          adv,
    output logic [AW-1:0] ptr_nxt,
    output logic          wrapped,
    output logic [AW-1:0] rem_nxt
);
    localparam logic [AW-1:0] RESTART = AW'(1);

    logic at_top;

    assign at_top  = (ptr >= size - AW'(1));
    assign wrapped = adv && at_top;

    always_comb begin
        if (!adv)        ptr_nxt = ptr;
        else if (at_top) ptr_nxt = RESTART;
        else             ptr_nxt = ptr + AW'(1);
    end

    assign rem_nxt = size - ptr_nxt;
endmodule

// File: rtl/can_rx_assembler.sv
module can_rx_assembler #(
    parameter int AW = 10,
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    cfg_mode,
    input  logic          cfg_frag_en,
    input  logic [AW-1:0] cfg_base,
    input  logic [AW-1:0] cfg_size,
    input  logic [AW-1:0] cfg_warn_thr,
    input  logic          frm_start,
    input  logic          frm_ide,
    input  logic          frm_rtr,
    input  logic          frm_sem1,
    input  logic          frm_sem0,
    input  logic [3:0]    frm_dlc,
    input  logic          dat_valid,
    input  logic [7:0]    dat_byte,
    input  logic          frm_done,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [7:0]    mem_wdata,
    output logic          irq_wrap_warn,
    output logic          buf_full
);
    import canrx_pkg::*;

    localparam logic [AW-1:0] OFS_FIRST = AW'(1);
    localparam logic [AW-1:0] FULL_LIM  = AW'(FULL_ROOM);
    localparam logic [3:0]    LIM_MAX   = 4'(MAX_DATA);

    typedef struct packed {
        logic [AW-1:0] ptr;
        logic [3:0]    idx;
        logic [3:0]    lim;
        logic          keep;
        logic          fin;
        logic          in_msg;
        logic [CW-1:0] exp;
        logic [7:0]    cnt;
        logic          armed;
        logic          full;
        logic          we;
        logic [AW-1:0] addr;
        logic [7:0]    wd;
        logic          irq;
    } st_t;

    st_t st_d, st_q;

    logic          raw_m, tl_m;
    logic          byte_ok, frag_slot;
    logic          stream_wr;
    logic [7:0]    stream_byte;
    logic [7:0]    info_byte;
    logic          fc_ok, fc_open, fc_close;
    logic [CW-1:0] fc_nxt;
    logic [AW-1:0] ring_nxt, ring_rem;
    logic          ring_wrap;

    canrx_info_pack u_info (
        .ide  (frm_ide),
        .rtr  (frm_rtr),
        .sem1 (frm_sem1),
        .sem0 (frm_sem0),
        .dlc  (frm_dlc),
        .info (info_byte)
    );

    canrx_frag_check #(.CW(CW)) u_frag (
        .fbyte   (dat_byte),
        .in_msg  (st_q.in_msg),
        .exp_cnt (st_q.exp),
        .ok      (fc_ok),
        .opens   (fc_open),
        .closes  (fc_close),
        .nxt_cnt (fc_nxt)
    );

    // decide which byte, if any, goes into the ring this cycle
    always_comb begin
        raw_m       = cfg_frag_en && (cfg_mode == MODE_RAW);
        tl_m        = cfg_frag_en && (cfg_mode != MODE_RAW);
        byte_ok     = dat_valid && cfg_frag_en && !frm_start && (st_q.idx < st_q.lim);
        frag_slot   = tl_m && byte_ok && (st_q.idx == 4'd0);
        stream_wr   = (raw_m && frm_start) || (byte_ok && !frag_slot && st_q.keep);
        stream_byte = frm_start ? info_byte : dat_byte;
    end

    canrx_ring #(.AW(AW)) u_ring (
        .ptr     (st_q.ptr),
        .size    (cfg_size),
        .adv     (stream_wr),
        .ptr_nxt (ring_nxt),
        .wrapped (ring_wrap),
        .rem_nxt (ring_rem)
    );

    always_comb begin
        st_d     = st_q;
        st_d.we  = 1'b0;
        st_d.irq = 1'b0;

        if (stream_wr) begin
            st_d.we   = 1'b1;
            st_d.addr = cfg_base + st_q.ptr;
            st_d.wd   = stream_byte;
            st_d.ptr  = ring_nxt;
            if (tl_m) st_d.cnt = st_q.cnt + 8'd1;
            if (ring_wrap) begin
                st_d.armed = 1'b1;
            end else if (st_q.armed && (ring_rem < cfg_warn_thr)) begin
                st_d.irq   = 1'b1;
                st_d.armed = 1'b0;
            end
        end

        if (frm_start && cfg_frag_en) begin
            st_d.idx  = 4'd0;
            st_d.lim  = (frm_dlc > LIM_MAX) ? LIM_MAX : frm_dlc;
            st_d.keep = raw_m;
            st_d.fin  = 1'b0;
        end else if (byte_ok) begin
            st_d.idx = st_q.idx + 4'd1;
            if (frag_slot) begin
                if (fc_ok) begin
                    st_d.keep = 1'b1;
                    st_d.fin  = fc_close;
                    st_d.exp  = fc_nxt;
                    if (fc_open) begin
                        st_d.in_msg = 1'b1;
                        st_d.ptr    = OFS_FIRST;
                        st_d.cnt    = 8'd0;
                        st_d.armed  = 1'b1;
                    end
                end else begin
                    st_d.keep   = 1'b0;
                    st_d.fin    = 1'b0;
                    st_d.in_msg = 1'b0;
                    st_d.ptr    = OFS_FIRST;
                    st_d.cnt    = 8'd0;
                end
            end
        end

        if (frm_done && cfg_frag_en) begin
            if (raw_m) st_d.full = ((cfg_size - st_q.ptr) < FULL_LIM);
            if (tl_m && st_q.keep && st_q.fin) begin
                st_d.we     = 1'b1;
                st_d.addr   = cfg_base;
                st_d.wd     = st_q.cnt;
                st_d.in_msg = 1'b0;
            end
            st_d.keep = 1'b0;
            st_d.fin  = 1'b0;
        end

        if (!raw_m) st_d.full = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.armed <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign mem_we        = st_q.we;
    assign mem_addr      = st_q.addr;
    assign mem_wdata     = st_q.wd;
    assign irq_wrap_warn = st_q.irq;
    assign buf_full      = st_q.full;
endmodule

// File: rtl/canrx_chk.sv
module canrx_chk #(
    parameter int AW = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic [1:0]    cfg_mode,
    input logic          cfg_frag_en,
    input logic [AW-1:0] cfg_base,
    input logic [AW-1:0] cfg_size,
    input logic          frm_done,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic          irq_wrap_warn,
    input logic          buf_full
);
    // R5
    addr_in_buf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (AW'(mem_addr - cfg_base) < cfg_size));

    // R6
    warn_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_wrap_warn |=> !irq_wrap_warn);

    // R6
    warn_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_wrap_warn |-> mem_we);

    // R4
    full_raw_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_frag_en && (cfg_mode == 2'b00)) |=> !buf_full);

    // R9
    count_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && (mem_addr == cfg_base) && (cfg_mode != 2'b00)) |-> $past(frm_done));

    // R11
    no_write_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_frag_en |=> !mem_we);
endmodule

bind can_rx_assembler canrx_chk #(.AW(AW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_mode      (cfg_mode),
    .cfg_frag_en   (cfg_frag_en),
    .cfg_base      (cfg_base),
    .cfg_size      (cfg_size),
    .frm_done      (frm_done),
    .mem_we        (mem_we),
    .mem_addr      (mem_addr),
    .irq_wrap_warn (irq_wrap_warn),
    .buf_full      (buf_full)
);

// File: tb/sim_can_rx_assembler.sv
`timescale 1ns/1ps
module sim_can_rx_assembler;
    localparam int AW = 10;
    localparam logic [AW-1:0] BASE = 10'h100;
    localparam logic [AW-1:0] SIZE = 10'd32;
    localparam logic [AW-1:0] THR  = 10'd6;

    // {hdr[24:21] ide,rtr,sem1,sem0 ; dlc[20:17] ; seed[16:9] ; ofs[8:1] ; full[0]}
    localparam logic [24:0] RAWV [5] = '{
        {4'b1010, 4'd8, 8'd10, 8'd0,  1'b0},
        {4'b0001, 4'd8, 8'd30, 8'd9,  1'b0},
        {4'b0100, 4'd3, 8'd50, 8'd18, 1'b0},
        {4'b1111, 4'd2, 8'd70, 8'd22, 1'b1},
        {4'b0000, 4'd8, 8'd90, 8'd25, 1'b0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    cfg_mode = 2'b00;
    logic          cfg_frag_en = 1'b1;
    logic [AW-1:0] cfg_base = BASE;
    logic [AW-1:0] cfg_size = SIZE;
    logic [AW-1:0] cfg_warn_thr = THR;
    logic          frm_start = 1'b0;
    logic          frm_ide = 1'b0, frm_rtr = 1'b0, frm_sem1 = 1'b0, frm_sem0 = 1'b0;
    logic [3:0]    frm_dlc = 4'd0;
    logic          dat_valid = 1'b0;
    logic [7:0]    dat_byte = 8'd0;
    logic          frm_done = 1'b0;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_wdata;
    logic          irq_wrap_warn;
    logic          buf_full;

    int checks = 0;
    int errors = 0;
    int wr_cnt = 0;
    int irq_cnt = 0;
    logic [AW-1:0] irq_addr = '0;
    logic [AW-1:0] last_addr = '0;
    logic [7:0]    shadow [0:(1<<AW)-1];

    always #2.5 clk = ~clk;

    can_rx_assembler #(.AW(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_frag_en(cfg_frag_en),
        .cfg_base(cfg_base), .cfg_size(cfg_size), .cfg_warn_thr(cfg_warn_thr),
        .frm_start(frm_start), .frm_ide(frm_ide), .frm_rtr(frm_rtr),
        .frm_sem1(frm_sem1), .frm_sem0(frm_sem0), .frm_dlc(frm_dlc),
        .dat_valid(dat_valid), .dat_byte(dat_byte), .frm_done(frm_done),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .irq_wrap_warn(irq_wrap_warn), .buf_full(buf_full)
    );

    always @(negedge clk) begin
        if (rst_n && mem_we) begin
            shadow[mem_addr] <= mem_wdata;
            last_addr        <= mem_addr;
            wr_cnt           <= wr_cnt + 1;
        end
        if (rst_n && irq_wrap_warn) begin
            irq_cnt  <= irq_cnt + 1;
            irq_addr <= mem_addr;
        end
    end

    task automatic check(input bit cond, input string req, input int act, input int exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send(input logic [3:0] hdr, input logic [3:0] dlc, input int nb,
                        input logic [7:0] b1, input logic [7:0] seed);
        @(negedge clk);
        frm_start = 1'b1;
        {frm_ide, frm_rtr, frm_sem1, frm_sem0} = hdr;
        frm_dlc = dlc;
        @(negedge clk);
        frm_start = 1'b0;
        for (int k = 1; k <= nb; k++) begin
            dat_valid = 1'b1;
            dat_byte  = (k == 1) ? b1 : 8'(seed + k);
            @(negedge clk);
        end
        dat_valid = 1'b0;
        frm_done  = 1'b1;
        @(negedge clk);
        frm_done = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    function automatic logic [AW-1:0] ring_at(input int ofs);
        int e = ofs;
        if (e >= int'(SIZE)) e = e - (int'(SIZE) - 1);
        return BASE + AW'(e);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int w0;
        do_reset();
        // R1 reset state
        check(mem_we == 1'b0, "R1 mem_we", int'(mem_we), 0);
        check(irq_wrap_warn == 1'b0, "R1 irq", int'(irq_wrap_warn), 0);
        check(buf_full == 1'b0, "R1 full", int'(buf_full), 0);

        // raw buffering table walk
        for (int i = 0; i < 5; i++) begin
            logic [3:0] hdr;
            logic [3:0] dlc;
            logic [7:0] seed;
            int ofs;
            bit okd;
            hdr  = RAWV[i][24:21];
            dlc  = RAWV[i][20:17];
            seed = RAWV[i][16:9];
            ofs  = int'(RAWV[i][8:1]);
            if (i == 4) irq_cnt = 0;
            send(hdr, dlc, int'(dlc), 8'(seed + 1), seed);
            // R2 header byte
            check(shadow[BASE + AW'(ofs)] == {hdr, dlc}, "R2 header",
                  int'(shadow[BASE + AW'(ofs)]), int'({hdr, dlc}));
            okd = 1'b1;
            for (int k = 1; k <= int'(dlc); k++)
                if (shadow[ring_at(ofs + k)] != 8'(seed + k)) okd = 1'b0;
            // R2 / R5 data bytes at consecutive, wrapped offsets
            check(okd, "R2 R5 data", int'(okd), 1);
            // R4 full after frame
            check(buf_full == RAWV[i][0], "R4 full", int'(buf_full), int'(RAWV[i][0]));
        end
        // R5 wrap lands on offset 1
        check(shadow[BASE + 10'd1] == 8'd97, "R5 wrap ofs1", int'(shadow[BASE + 10'd1]), 97);
        // R6 one warning, at the write to offset 26
        check(irq_cnt == 1, "R6 warn count", irq_cnt, 1);
        check(irq_addr == BASE + 10'd26, "R6 warn addr", int'(irq_addr), int'(BASE + 10'd26));

        // R3 bytes beyond DLC ignored
        w0 = wr_cnt;
        send(4'b0000, 4'd2, 4, 8'hA1, 8'hA0);
        check(wr_cnt - w0 == 3, "R3 extra bytes", wr_cnt - w0, 3);

        // R11 disabled object writes nothing
        cfg_frag_en = 1'b0;
        w0 = wr_cnt;
        send(4'b0000, 4'd4, 4, 8'hB1, 8'hB0);
        check(wr_cnt - w0 == 0, "R11 disabled", wr_cnt - w0, 0);
        cfg_frag_en = 1'b1;

        // transport reassembly
        cfg_mode = 2'b01;
        do_reset();
        w0 = wr_cnt;
        send(4'b0000, 4'd8, 8, 8'h40, 8'h20);
        send(4'b0000, 4'd5, 5, 8'h81, 8'h40);
        send(4'b0000, 4'd3, 3, 8'hC2, 8'h60);
        check(wr_cnt - w0 == 14, "R7 write count", wr_cnt - w0, 14);
        check(shadow[BASE + 10'd1] == 8'h22, "R7 first stored", int'(shadow[BASE + 10'd1]), 'h22);
        check(shadow[BASE + 10'd8] == 8'h42, "R8 append", int'(shadow[BASE + 10'd8]), 'h42);
        check(shadow[BASE + 10'd13] == 8'h63, "R8 tail", int'(shadow[BASE + 10'd13]), 'h63);
        check(shadow[BASE] == 8'd13, "R9 count", int'(shadow[BASE]), 13);
        check(last_addr == BASE, "R9 count last", int'(last_addr), int'(BASE));
        check(buf_full == 1'b0, "R4 full transport", int'(buf_full), 0);

        // R10 sequence errors
        w0 = wr_cnt;
        send(4'b0000, 4'd4, 4, 8'h40, 8'h70);
        check(wr_cnt - w0 == 3, "R10 open", wr_cnt - w0, 3);
        w0 = wr_cnt;
        send(4'b0000, 4'd4, 4, 8'h85, 8'h78);
        check(wr_cnt - w0 == 0, "R10 bad counter", wr_cnt - w0, 0);
        w0 = wr_cnt;
        send(4'b0000, 4'd3, 3, 8'hC1, 8'h7C);
        check(wr_cnt - w0 == 0, "R10 no message", wr_cnt - w0, 0);
        w0 = wr_cnt;
        send(4'b0000, 4'd4, 4, 8'h00, 8'h90);
        check(wr_cnt - w0 == 4, "R8 single writes", wr_cnt - w0, 4);
        check(shadow[BASE + 10'd1] == 8'h92, "R10 restart ofs1", int'(shadow[BASE + 10'd1]), 'h92);
        check(shadow[BASE] == 8'd3, "R9 single count", int'(shadow[BASE]), 3);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule